// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block runs the stack-touching instructions of a small 8-bit processor core. It owns the 8-bit stack pointer. It drives a single-port byte memory with one access per cycle, and some cycles make no access at all. The core starts an operation with a one-cycle `start` pulse, an operation code on `op`, and the current program counter, status byte and accumulator. On `start` the block captures those three values into working registers. It then steps through a fixed per-operation schedule of memory reads, memory writes and idle cycles. When the schedule ends it pulses `done`. At that point `pc_out`, `status_out`, `acc_out`, `sp_out` and `cyc_count` hold the results.

The stack always lives in the page at 0x0100–0x01FF. A push writes at the current pointer and then decrements it. A pull increments the pointer and then reads. Seven operations are supported: push accumulator, push status, pull accumulator, pull status, call, return from subroutine and return from interrupt. The status byte needs special handling. Bit 4 is forced high in any pushed status byte. Bits 5 and 4 are never taken from memory on a status pull.

The memory port has no back-pressure. Read data must be valid in the same cycle as the address, and a write happens at the clock edge that ends the cycle in which `mem_we` is high. The control pins are plain levels and pulses. While `busy` is high a new `start` is ignored.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp_out` is 0xFD, `status_out` is 0x34, `acc_out` and `pc_out` are 0, and `done`, `busy`, `mem_req` and `mem_we` are low.
- R2: Every stack access uses address 0x0100 | pointer. A push writes at the current pointer and then decrements it. A pull first increments the pointer and then reads at the new value.
- R3: Operation code 0 (push accumulator) takes 2 cycles: one write of the captured accumulator, then one idle cycle.
- R4: Operation code 1 (push status) takes 2 cycles: one write of the captured status OR 0x10, then one idle cycle.
- R5: Operation code 2 (pull accumulator) takes 3 cycles: one read, then two idle cycles. The accumulator becomes the read byte. Status bit 7 becomes bit 7 of that byte, and status bit 1 is set exactly when that byte is zero. All other status bits are kept.
- R6: Operation code 3 (pull status) takes 3 cycles: one read, then two idle cycles. Status bits 7, 6, 3, 2, 1 and 0 come from memory. Bits 5 and 4 are kept from the captured status.
- R7: Operation code 4 (call) takes 5 cycles. The order is: one idle cycle; a push of the high byte of PC+1; a push of the low byte of PC+1; a read at PC; a read at PC+1. The new PC is (byte read at PC+1) × 256 + (byte read at PC).
- R8: Operation code 5 (return from subroutine) takes 5 cycles: pull the low byte, pull the high byte, then three idle cycles. The new PC is the pulled value plus 1, modulo 65536.
- R9: Operation code 6 (return from interrupt) takes 5 cycles. It first pulls the status with the same masking as R6, then has two idle cycles, then pulls the PC low byte and the high byte. The PC is the pulled value with nothing added.
- R10: The stack pointer wraps modulo 256 in both directions. A wrap raises no indication.
- R11: `done` is high for exactly one cycle, one cycle after the last step, and at that time `cyc_count` holds the number of cycles in the operation. A `start` while `busy` is high is ignored, as is operation code 7. No memory access happens while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| op | input | 3 | Operation code, 0–6 as listed in the requirements |
| pc_in | input | 16 | Program counter from the core, captured on start |
| status_in | input | 8 | Status byte from the core, captured on start |
| acc_in | input | 8 | Accumulator from the core, captured on start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| status_out | output | 8 | Resulting status byte |
| acc_out | output | 8 | Resulting accumulator |
| sp_out | output | 8 | Current stack pointer |
| cyc_count | output | 3 | Cycles used by the last completed operation |
| mem_req | output | 1 | A memory access happens this cycle |
| mem_we | output | 1 | The access this cycle is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |

## Verification
Call E0 the clock edge that samples `start`. Step k of an operation appears on the memory port in the cycle that follows edge E0+k. `done` and the final register values appear after edge E0+L, where L is the operation length. The bench drives and samples only at falling edges and counts them from the start pulse. It records the memory port on each falling edge while `busy` is high, and it requires `done` at exactly falling edge L+1. The expected access list and results are built from a snapshot of the bench's own stack page taken before the operation starts. Because of this, wrong ordering, wrong masking or a cycle that is off by one all show up as a mismatch at a specific step.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2 * DATA_W;
  localparam int IDX_W     = 3;
  localparam int CNT_W     = 3;
  localparam logic [DATA_W-1:0] PULL_MASK = 8'hCF;
  localparam logic [DATA_W-1:0] KEEP_MASK = 8'h30;
  localparam logic [DATA_W-1:0] BRK_SET   = 8'h10;
  localparam int NEG_BIT  = 7;
  localparam int ZERO_BIT = 1;

  typedef enum logic [2:0] {
    OP_PSHA = 3'd0, OP_PSHP = 3'd1, OP_PULA = 3'd2, OP_PULP = 3'd3,
    OP_CALL = 3'd4, OP_RTS  = 3'd5, OP_RTI  = 3'd6, OP_NONE = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_A, ST_WR_P, ST_WR_PCH, ST_WR_PCL,
    ST_RD_A, ST_RD_P, ST_RD_PCL, ST_RD_PCH, ST_OP_L, ST_OP_H
  } act_e;

  function automatic logic [CNT_W-1:0] op_len(op_e o);
    case (o)
      OP_PSHA, OP_PSHP:         op_len = 3'd2;
      OP_PULA, OP_PULP:         op_len = 3'd3;
      OP_CALL, OP_RTS, OP_RTI:  op_len = 3'd5;
      default:                  op_len = 3'd0;
    endcase
  endfunction

  function automatic act_e step_act(op_e o, logic [IDX_W-1:0] idx);
    act_e a;
    a = ST_IDLE;
    case (o)
      OP_PSHA: if (idx == 3'd0) a = ST_WR_A;
      OP_PSHP: if (idx == 3'd0) a = ST_WR_P;
      OP_PULA: if (idx == 3'd0) a = ST_RD_A;
      OP_PULP: if (idx == 3'd0) a = ST_RD_P;
      OP_CALL: case (idx)
                 3'd1: a = ST_WR_PCH;
                 3'd2: a = ST_WR_PCL;
                 3'd3: a = ST_OP_L;
                 3'd4: a = ST_OP_H;
                 default: a = ST_IDLE;
               endcase
      OP_RTS:  case (idx)
                 3'd0: a = ST_RD_PCL;
                 3'd1: a = ST_RD_PCH;
                 default: a = ST_IDLE;
               endcase
      OP_RTI:  case (idx)
                 3'd0: a = ST_RD_P;
                 3'd3: a = ST_RD_PCL;
                 3'd4: a = ST_RD_PCH;
                 default: a = ST_IDLE;
               endcase
      default: a = ST_IDLE;
    endcase
    return a;
  endfunction

  function automatic logic is_push(act_e a);
    return (a == ST_WR_A) || (a == ST_WR_P) || (a == ST_WR_PCH) || (a == ST_WR_PCL);
  endfunction

  function automatic logic is_pull(act_e a);
    return (a == ST_RD_A) || (a == ST_RD_P) || (a == ST_RD_PCL) || (a == ST_RD_PCH);
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op_in,
  output logic             busy,
  output logic             done,
  output logic             load,
  output op_e              op_q,
  output act_e             act,
  output logic [CNT_W-1:0] cyc_count
);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] len;

  assign load = start && !busy && (op_e'(op_in) != OP_NONE);
  assign len  = op_len(op_q);
  assign act  = busy ? step_act(op_q, idx) : ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      idx       <= '0;
      op_q      <= OP_NONE;
      cyc_count <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
        op_q <= op_e'(op_in);
      end else if (busy) begin
        if (idx == len - 3'd1) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          cyc_count <= len;
        end else begin
          idx <= idx + 3'd1;
        end
      end
    end
  end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int          SP_W     = 8,
  parameter int          PAGE_W   = 8,
  parameter logic [7:0]  SP_RESET = 8'hFD,
  parameter logic [7:0]  PAGE     = 8'h01
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  act_e                   act,
  output logic [SP_W-1:0]        sp,
  output logic [SP_W+PAGE_W-1:0] stk_addr
);

  logic [SP_W-1:0] sp_inc;
  assign sp_inc   = sp + 1'b1;
  assign stk_addr = {PAGE[PAGE_W-1:0], is_pull(act) ? sp_inc : sp};

  always_ff @(posedge clk) begin
    if (!rst_n)              sp <= SP_RESET[SP_W-1:0];
    else if (is_push(act))   sp <= sp - 1'b1;
    else if (is_pull(act))   sp <= sp_inc;
  end

endmodule

// File: rtl/stk_dp.sv
module stk_dp
  import stk_pkg::*;
#(
  parameter logic [7:0] STATUS_RESET = 8'h34
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] acc_in,
  input  act_e              act,
  input  op_e               op_q,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] opnd_addr
);

  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] pc_p1;
  logic [DATA_W-1:0] pulled_status;
  logic [ADDR_W-1:0] joined;

  assign pc_p1         = pc + 1'b1;
  assign opnd_addr     = (act == ST_OP_H) ? pc_p1 : pc;
  assign pulled_status = (rdata & PULL_MASK) | (status & KEEP_MASK);
  assign joined        = {rdata, lo_q};

  always_comb begin
    case (act)
      ST_WR_A:   wdata = acc;
      ST_WR_P:   wdata = status | BRK_SET;
      ST_WR_PCH: wdata = pc_p1[ADDR_W-1:DATA_W];
      ST_WR_PCL: wdata = pc_p1[DATA_W-1:0];
      default:   wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      status <= STATUS_RESET;
      acc    <= '0;
      lo_q   <= '0;
    end else if (load) begin
      pc     <= pc_in;
      status <= status_in;
      acc    <= acc_in;
    end else begin
      case (act)
        ST_RD_A: begin
          acc                <= rdata;
          status[NEG_BIT]    <= rdata[DATA_W-1];
          status[ZERO_BIT]   <= (rdata == '0);
        end
        ST_RD_P:             status <= pulled_status;
        ST_RD_PCL, ST_OP_L:  lo_q   <= rdata;
        ST_RD_PCH:           pc     <= joined + {{(ADDR_W-1){1'b0}}, (op_q == OP_RTS)};
        ST_OP_H:             pc     <= joined;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_pkg::*;
#(
  parameter logic [7:0] SP_RESET     = 8'hFD,
  parameter logic [7:0] STATUS_RESET = 8'h34,
  parameter logic [7:0] STACK_PAGE   = 8'h01
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] status_out,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [CNT_W-1:0]  cyc_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              load;
  op_e               op_q;
  act_e              act;
  logic [ADDR_W-1:0] stk_addr;
  logic [ADDR_W-1:0] opnd_addr;

  stk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op),
    .busy(busy), .done(done), .load(load), .op_q(op_q), .act(act),
    .cyc_count(cyc_count)
  );

  stk_ptr #(
    .SP_W(DATA_W), .PAGE_W(ADDR_W - DATA_W),
    .SP_RESET(SP_RESET), .PAGE(STACK_PAGE)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .act(act), .sp(sp_out), .stk_addr(stk_addr)
  );

  stk_dp #(.STATUS_RESET(STATUS_RESET)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load),
    .pc_in(pc_in), .status_in(status_in), .acc_in(acc_in),
    .act(act), .op_q(op_q), .rdata(mem_rdata),
    .pc(pc_out), .status(status_out), .acc(acc_out),
    .wdata(mem_wdata), .opnd_addr(opnd_addr)
  );

  assign mem_req  = (act != ST_IDLE);
  assign mem_we   = is_push(act);
  assign mem_addr = (is_push(act) || is_pull(act)) ? stk_addr :
                    ((act == ST_OP_L) || (act == ST_OP_H)) ? opnd_addr : '0;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  op,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp_out
);

  assert_stack_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == 8'h01));

  assert_push_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op != 3'd7)) |=> busy);

endmodule

bind stack_seq stack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .sp_out(sp_out)
);

// File: tb/sim_stack_seq.sv
module sim_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] pc_i = '0;
  logic [7:0]  st_i = '0;
  logic [7:0]  ac_i = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  status_out, acc_out, sp_out, mem_wdata, mem_rdata;
  logic [2:0]  cyc_count;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_sp;

  logic [7:0]  stk [256];
  logic        er [8];
  logic        ew [8];
  logic [15:0] ea [8];
  logic [7:0]  ed [8];
  logic        lr [8];
  logic        lw [8];
  logic [15:0] la [8];
  logic [7:0]  ld [8];

  always #4 clk = ~clk;

  function automatic logic [7:0] opnd(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : opnd(mem_addr);

  always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .pc_in(pc_i),
    .status_in(st_i), .acc_in(ac_i), .busy(busy), .done(done),
    .pc_out(pc_out), .status_out(status_out), .acc_out(acc_out),
    .sp_out(sp_out), .cyc_count(cyc_count), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] actual, input logic [31:0] expect_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expect_v);
    end
  endtask

  task automatic put(input int k, input logic r, input logic w,
                     input logic [15:0] a, input logic [7:0] d);
    er[k] = r; ew[k] = w; ea[k] = a; ed[k] = d;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] pc, input logic [7:0] st,
                        input logic [7:0] ac, input bit dbl, input string tag);
    logic [7:0]  s1, s2, s3, v, sm1, xp_st, xp_ac, xp_sp;
    logic [15:0] xp_pc, t;
    int el, n, k;
    string sp_tag;
    s1 = m_sp + 8'd1; s2 = m_sp + 8'd2; s3 = m_sp + 8'd3; sm1 = m_sp - 8'd1;
    xp_pc = pc; xp_st = st; xp_ac = ac; xp_sp = m_sp; el = 0;
    for (int j = 0; j < 8; j++) put(j, 1'b0, 1'b0, 16'h0, 8'h0);
    case (o)
      3'd0: begin put(0, 1, 1, {8'h01, m_sp}, ac); el = 2; xp_sp = sm1; end
      3'd1: begin put(0, 1, 1, {8'h01, m_sp}, st | 8'h10); el = 2; xp_sp = sm1; end
      3'd2: begin
        v = stk[s1]; put(0, 1, 0, {8'h01, s1}, 8'h0); el = 3; xp_sp = s1; xp_ac = v;
        xp_st = (st & 8'h7D) | (v & 8'h80) | ((v == 8'h00) ? 8'h02 : 8'h00);
      end
      3'd3: begin
        v = stk[s1]; put(0, 1, 0, {8'h01, s1}, 8'h0); el = 3; xp_sp = s1;
        xp_st = (v & 8'hCF) | (st & 8'h30);
      end
      3'd4: begin
        t = pc + 16'd1;
        put(1, 1, 1, {8'h01, m_sp}, t[15:8]);
        put(2, 1, 1, {8'h01, sm1}, t[7:0]);
        put(3, 1, 0, pc, 8'h0);
        put(4, 1, 0, t, 8'h0);
        el = 5; xp_sp = m_sp - 8'd2; xp_pc = {opnd(t), opnd(pc)};
      end
      3'd5: begin
        put(0, 1, 0, {8'h01, s1}, 8'h0); put(1, 1, 0, {8'h01, s2}, 8'h0);
        el = 5; xp_sp = s2; xp_pc = {stk[s2], stk[s1]} + 16'd1;
      end
      default: begin
        put(0, 1, 0, {8'h01, s1}, 8'h0); put(3, 1, 0, {8'h01, s2}, 8'h0);
        put(4, 1, 0, {8'h01, s3}, 8'h0);
        el = 5; xp_sp = s3; xp_st = (stk[s1] & 8'hCF) | (st & 8'h30);
        xp_pc = {stk[s3], stk[s2]};
      end
    endcase
    sp_tag = ((o == 3'd0 || o == 3'd1 || o == 3'd4) && xp_sp > m_sp) ||
             ((o == 3'd2 || o == 3'd3 || o >= 3'd5) && xp_sp < m_sp) ? "R10" : "R2";

    @(negedge clk);
    op_i = o; pc_i = pc; st_i = st; ac_i = ac; start = 1'b1;
    @(negedge clk);
    if (dbl) op_i = 3'd2; else start = 1'b0;
    n = 1; k = 0;
    forever begin
      if (busy && k < 8) begin
        lr[k] = mem_req; lw[k] = mem_we; la[k] = mem_addr; ld[k] = mem_wdata; k++;
      end
      if (done || n > 12) break;
      @(negedge clk);
      start = 1'b0;
      n++;
    end

    chk(n == el + 1, "R11", "done latency", n, el + 1);
    chk(k == el, tag, "step count", k, el);
    for (int j = 0; j < el && j < k; j++) begin
      chk(lr[j] == er[j] && lw[j] == ew[j], tag, "access kind", {lr[j], lw[j]}, {er[j], ew[j]});
      if (er[j]) chk(la[j] == ea[j], (ew[j] || er[j]) && ea[j][15:8] == 8'h01 ? "R2" : tag,
                     "address", la[j], ea[j]);
      if (ew[j]) chk(ld[j] == ed[j], tag, "write data", ld[j], ed[j]);
    end
    chk(sp_out == xp_sp, sp_tag, "stack pointer", sp_out, xp_sp);
    chk(pc_out == xp_pc, tag, "pc", pc_out, xp_pc);
    chk(status_out == xp_st, tag, "status", status_out, xp_st);
    chk(acc_out == xp_ac, tag, "accumulator", acc_out, xp_ac);
    chk(cyc_count == el[2:0], "R11", "cycle count", cyc_count, el);
    m_sp = xp_sp;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    string tags [7];
    tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";
    tags[4] = "R7"; tags[5] = "R8"; tags[6] = "R9";
    for (int j = 0; j < 256; j++) stk[j] = 8'(j * 7 + 3);
    m_sp = 8'hFD;

    repeat (3) @(negedge clk);
    chk(sp_out == 8'hFD, "R1", "reset sp", sp_out, 8'hFD);
    chk(status_out == 8'h34, "R1", "reset status", status_out, 8'h34);
    chk(acc_out == 8'h00 && pc_out == 16'h0, "R1", "reset acc/pc", {acc_out, pc_out}, 0);
    chk(!done && !busy && !mem_req && !mem_we, "R1", "reset controls",
        {done, busy, mem_req, mem_we}, 0);
    rst_n = 1'b1;

    // R8: 0xFFFF + 1 wraps to 0x0000
    stk[8'hFE] = 8'hFF; stk[8'hFF] = 8'hFF;
    run_op(3'd5, 16'h9000, 8'h21, 8'h44, 1'b0, "R8");
    chk(pc_out == 16'h0000, "R8", "return wrap", pc_out, 16'h0000);

    // R11: reserved code ignored
    @(negedge clk);
    op_i = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 3; j++) begin
      chk(!busy && !mem_req, "R11", "reserved op idle", {busy, mem_req}, 0);
      @(negedge clk);
    end
    chk(sp_out == m_sp && !done, "R11", "reserved op no effect", sp_out, m_sp);

    // R11: start during busy ignored
    run_op(3'd0, 16'h8123, 8'h00, 8'hA5, 1'b1, "R11");

    // R5: zero pull sets Z
    stk[8'(m_sp + 8'd1)] = 8'h00;
    run_op(3'd2, 16'h8000, 8'hC3, 8'h11, 1'b0, "R5");

    for (int i = 0; i < 420; i++) begin
      logic [2:0] o;
      o = 3'(i % 7);
      run_op(o, {1'b1, 15'(i * 97)}, 8'(i * 53 + 11), 8'(i * 37 + 5), 1'b0, tags[o]);
    end

    // R10: long push run crossing 0x00 -> 0xFF
    for (int i = 0; i < 260; i++) begin
      logic [2:0] o;
      o = (i % 2 == 0) ? 3'd0 : 3'd1;
      run_op(o, 16'h8000, 8'(i * 29), 8'(i * 13), 1'b0, (i % 2 == 0) ? "R3" : "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule